// File: doc/BRIEF.md
# Timer Interrupt Status Flags

This block keeps the sticky interrupt and status flags of a general-purpose timer. The timer core hands it single-cycle event pulses: counter update, a compare/capture event per channel (four channels), and commutation. It also receives the raw trigger input, which it synchronizes and edge-detects itself, and a break level that is already qualified as active. Every event sets a flag that stays set until software clears it. A channel in capture mode that captures again while its capture flag is still pending also raises that channel's over-capture flag.

Software sees every flag in one 32-bit status word on a simple read/write port. A write clears each flag whose bit is written as 0 and leaves each flag whose bit is written as 1 unchanged, so software can clear chosen flags without a read-modify-write race. A single interrupt line is the OR of every flag gated by its own enable bit.

Top module: `tmr_status_flags`

## Requirements
- R1: Status word bit positions: bit 0 is the update flag and bits 1, 2, 3, 4 are the channel 0..3 capture/compare flags. Each is set one cycle after its event pulse, whatever the channel mode is.
- R2: A write (wr_en high) clears every flag whose bit in wr_data is 0 and leaves every flag whose bit is 1 unchanged. Flags stay set with no write.
- R3: If a hardware set and a write-0 clear hit the same flag in the same cycle, the flag ends up set. Other flags cleared by that write still clear.
- R4: Bits 9..12 are the channel 0..3 over-capture flags. One is set when its channel's event arrives while ch_input_mode for that channel is 1 and that channel's capture flag was already set at the start of the cycle. A channel with ch_input_mode 0 never sets it.
- R5: Bit 5 is the commutation flag. It is set by evt_commut and stays set until a write-0 clears it.
- R6: trig_in passes through a two-flop synchronizer, so bit 6 (trigger flag) is set on the third rising clock edge after trig_in changes. Outside pause mode only the selected edge counts: trig_pol 0 selects rising and trig_pol 1 selects falling.
- R7: With pause_mode 1, both rising and falling trig_in edges set the trigger flag, whatever trig_pol is.
- R8: Bit 7 is the break flag. It is set in every cycle in which brk_active is 1, so a write-0 does not clear it while brk_active stays 1.
- R9: Bit 8 and bits 31..13 always read 0 and ignore writes.
- R10: irq is 1 exactly when some status bit and the same bit of irq_en are both 1.
- R11: A synchronous active-high rst clears all flags and the trigger synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Write data; 0 clears a flag, 1 keeps it |
| rd_data | output | 32 | Current status word |
| evt_update | input | 1 | Counter update event pulse |
| evt_ch | input | 4 | Per-channel compare/capture event pulses |
| ch_input_mode | input | 4 | Per-channel capture (input) mode |
| evt_commut | input | 1 | Commutation event pulse |
| trig_in | input | 1 | Asynchronous trigger input |
| trig_pol | input | 1 | Active trigger edge: 0 rising, 1 falling |
| pause_mode | input | 1 | Pause slave mode: both edges trigger |
| brk_active | input | 1 | Qualified active break level |
| irq_en | input | 32 | Per-bit interrupt enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Each event source is pulsed on its own and then in combination with writes. Writes of all-zero, all-one and mixed patterns separate write-0 clearing from write-1 keeping. A repeated capture in input mode is set against the same repeat in output mode, which shows that over-capture depends on both the pending flag and the mode. Trigger edges of both directions are applied under both polarities and in pause mode, and the flag is sampled both one cycle before and at the third synchronizer edge, so the timing is checked along with the edge selection. A held break level and a set coinciding with a clear show that a hardware set beats a software clear.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;

    // Channel count is fixed by the status word layout
    localparam int NUM_CH   = 4;
    localparam int WORD_W   = 32;

    // Bit positions inside the status word
    localparam int POS_UPD  = 0;
    localparam int POS_CH0  = POS_UPD + 1;
    localparam int POS_CMT  = POS_CH0 + NUM_CH;
    localparam int POS_TRG  = POS_CMT + 1;
    localparam int POS_BRK  = POS_TRG + 1;
    localparam int POS_RSV  = POS_BRK + 1;
    localparam int POS_OVF0 = POS_RSV + 1;
    localparam int FLAG_W   = POS_OVF0 + NUM_CH;

    typedef logic [FLAG_W-1:0] flag_vec_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    // Hardware set requests, grouped by source
    typedef struct packed {
        logic              upd;
        logic [NUM_CH-1:0] ch;
        logic              cmt;
        logic              trg;
        logic              brk;
        logic [NUM_CH-1:0] ovf;
    } hw_set_t;

    // Map grouped set requests onto status word positions
    function automatic flag_vec_t place_sets(hw_set_t s);
        flag_vec_t v;
        v                    = '0;
        v[POS_UPD]           = s.upd;
        v[POS_CH0 +: NUM_CH] = s.ch;
        v[POS_CMT]           = s.cmt;
        v[POS_TRG]           = s.trg;
        v[POS_BRK]           = s.brk;
        v[POS_OVF0 +: NUM_CH] = s.ovf;
        return v;
    endfunction

    // Positions that hold a real flag
    function automatic flag_vec_t impl_mask();
        flag_vec_t m;
        m          = '1;
        m[POS_RSV] = 1'b0;
        return m;
    endfunction

    // Zero-extend the flag vector to the bus width
    function automatic word_t to_word(flag_vec_t f);
        word_t w;
        w              = '0;
        w[FLAG_W-1:0]  = f;
        return w;
    endfunction

endpackage

// File: rtl/tmr_trig_edge.sv
module tmr_trig_edge
    import tmr_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      trig_in,
    input  edge_pol_e pol,
    input  logic      both_edges,
    output logic      trig_evt
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise;
    logic                   fall;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= trig_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[MSB];
    end

    assign rise = sync_q[MSB] & ~last_q;
    assign fall = ~sync_q[MSB] & last_q;

    always_comb begin
        if (both_edges)            trig_evt = rise | fall;
        else if (pol == EDGE_FALL) trig_evt = fall;
        else                       trig_evt = rise;
    end

endmodule

// File: rtl/tmr_ovcap.sv
module tmr_ovcap
    import tmr_flag_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic [CH-1:0] cap_evt,
    input  logic [CH-1:0] input_mode,
    input  logic [CH-1:0] cap_flag_q,
    output logic [CH-1:0] ovf_set
);
    genvar i;
    generate
        for (i = 0; i < CH; i++) begin : g_ch
            // A second capture while the first is unread is an overrun
            assign ovf_set[i] = cap_evt[i] & input_mode[i] & cap_flag_q[i];
        end
    endgenerate

endmodule

// File: rtl/tmr_sticky_bank.sv
module tmr_sticky_bank #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_req,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (MASK[i]) begin : g_flop
                always_ff @(posedge clk) begin
                    if (rst)                     q[i] <= 1'b0;
                    else if (set_req[i])         q[i] <= 1'b1;
                    else if (wr_en && !wr_data[i]) q[i] <= 1'b0;
                end
            end else begin : g_tie
                assign q[i] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/tmr_status_flags.sv
module tmr_status_flags
    import tmr_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              evt_update,
    input  logic [NUM_CH-1:0] evt_ch,
    input  logic [NUM_CH-1:0] ch_input_mode,
    input  logic              evt_commut,
    input  logic              trig_in,
    input  logic              trig_pol,
    input  logic              pause_mode,
    input  logic              brk_active,
    input  logic [WORD_W-1:0] irq_en,
    output logic              irq
);
    localparam flag_vec_t MASK = impl_mask();

    flag_vec_t         flags_q;
    flag_vec_t         set_vec;
    hw_set_t           sets;
    logic              trig_evt;
    logic [NUM_CH-1:0] ovf_set;
    edge_pol_e         pol;

    assign pol = edge_pol_e'(trig_pol);

    tmr_trig_edge #(
        .SYNC_STAGES(2)
    ) u_trig (
        .clk       (clk),
        .rst       (rst),
        .trig_in   (trig_in),
        .pol       (pol),
        .both_edges(pause_mode),
        .trig_evt  (trig_evt)
    );

    tmr_ovcap #(
        .CH(NUM_CH)
    ) u_ovcap (
        .cap_evt   (evt_ch),
        .input_mode(ch_input_mode),
        .cap_flag_q(flags_q[POS_CH0 +: NUM_CH]),
        .ovf_set   (ovf_set)
    );

    always_comb begin
        sets.upd = evt_update;
        sets.ch  = evt_ch;
        sets.cmt = evt_commut;
        sets.trg = trig_evt;
        sets.brk = brk_active;
        sets.ovf = ovf_set;
        set_vec  = place_sets(sets);
    end

    tmr_sticky_bank #(
        .W   (FLAG_W),
        .MASK(MASK)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_req(set_vec),
        .wr_en  (wr_en),
        .wr_data(wr_data[FLAG_W-1:0]),
        .q      (flags_q)
    );

    assign rd_data = to_word(flags_q);
    assign irq     = |(rd_data & irq_en);

endmodule

// File: rtl/tmr_status_flags_chk.sv
module tmr_status_flags_chk
    import tmr_flag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic              evt_update,
    input logic [NUM_CH-1:0] evt_ch,
    input logic [NUM_CH-1:0] ch_input_mode,
    input logic              evt_commut,
    input logic              brk_active
);
    AST_UPD_SETS: assert property (@(posedge clk) disable iff (rst)
        evt_update |=> rd_data[POS_UPD]);  // R1

    AST_UPD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[POS_UPD] && !evt_update) |=> !rd_data[POS_UPD]);  // R2

    AST_CMT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rd_data[POS_CMT] && !(wr_en && !wr_data[POS_CMT])) |=> rd_data[POS_CMT]);  // R5

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        (evt_commut && wr_en && !wr_data[POS_CMT]) |=> rd_data[POS_CMT]);  // R3

    AST_OVF0_SET: assert property (@(posedge clk) disable iff (rst)
        (evt_ch[0] && ch_input_mode[0] && rd_data[POS_CH0]) |=> rd_data[POS_OVF0]);  // R4

    AST_BRK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        brk_active |=> rd_data[POS_BRK]);  // R8

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data[WORD_W-1:FLAG_W] == '0) && !rd_data[POS_RSV]);  // R9

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (rd_data == '0));  // R11

endmodule

bind tmr_status_flags tmr_status_flags_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .evt_update   (evt_update),
    .evt_ch       (evt_ch),
    .ch_input_mode(ch_input_mode),
    .evt_commut   (evt_commut),
    .brk_active   (brk_active)
);

// File: tb/tmr_status_flags_tb.sv
module tmr_status_flags_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        evt_update;
    logic [3:0]  evt_ch;
    logic [3:0]  ch_input_mode;
    logic        evt_commut;
    logic        trig_in;
    logic        trig_pol;
    logic        pause_mode;
    logic        brk_active;
    logic [31:0] irq_en;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    tmr_status_flags u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .evt_update   (evt_update),
        .evt_ch       (evt_ch),
        .ch_input_mode(ch_input_mode),
        .evt_commut   (evt_commut),
        .trig_in      (trig_in),
        .trig_pol     (trig_pol),
        .pause_mode   (pause_mode),
        .brk_active   (brk_active),
        .irq_en       (irq_en),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic clear_all();
        write_word(32'h0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        wr_en = 0; wr_data = 0; evt_update = 0; evt_ch = 0; ch_input_mode = 0;
        evt_commut = 0; trig_in = 0; trig_pol = 0; pause_mode = 0;
        brk_active = 0; irq_en = 0;
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset state", rd_data, 32'h0);
        chk("R11 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_update_channels();
        evt_update = 1'b1;
        @(negedge clk);
        evt_update = 1'b0;
        chk("R1 update flag bit0", rd_data, 32'h1);
        evt_ch = 4'b1010;
        @(negedge clk);
        evt_ch = 4'b0000;
        chk("R1 channel flags 1,3", rd_data, 32'h0000_0015);
        evt_ch = 4'b0101;
        @(negedge clk);
        evt_ch = 4'b0000;
        chk("R1 all channel flags", rd_data, 32'h0000_001F);
        wait_cyc(3);
        chk("R2 flags held without write", rd_data, 32'h0000_001F);
    endtask

    task automatic t_write_clear();
        write_word(32'hFFFF_FFFF);
        chk("R2 write ones keeps all", rd_data, 32'h0000_001F);
        write_word(32'hFFFF_FFF5);
        chk("R2 write zero clears ch0,ch2", rd_data, 32'h0000_0015);
        clear_all();
        chk("R2 write all zero clears", rd_data, 32'h0);
    endtask

    task automatic t_set_wins();
        evt_ch = 4'b0001;
        @(negedge clk);
        evt_ch = 4'b0000;
        evt_update = 1'b1;
        wr_en = 1'b1; wr_data = 32'h0;
        @(negedge clk);
        evt_update = 1'b0;
        wr_en = 1'b0;
        chk("R3 set beats clear, other cleared", rd_data, 32'h1);
        clear_all();
    endtask

    task automatic t_overcapture();
        ch_input_mode = 4'b0001;
        evt_ch = 4'b0011;
        @(negedge clk);
        evt_ch = 4'b0000;
        chk("R4 first capture no overrun", rd_data, 32'h0000_0006);
        evt_ch = 4'b0011;
        @(negedge clk);
        evt_ch = 4'b0000;
        chk("R4 overrun ch0 only (ch1 output mode)", rd_data, 32'h0000_0206);
        ch_input_mode = 4'b1000;
        evt_ch = 4'b1000;
        @(negedge clk);
        evt_ch = 4'b1000;
        @(negedge clk);
        evt_ch = 4'b0000;
        chk("R4 overrun ch3 bit12", rd_data, 32'h0000_1216);
        write_word(32'hFFFF_FDFF);
        chk("R2 clear ch0 overrun only", rd_data, 32'h0000_1016);
        clear_all();
        ch_input_mode = 4'b0000;
    endtask

    task automatic t_commut();
        evt_commut = 1'b1;
        @(negedge clk);
        evt_commut = 1'b0;
        chk("R5 commutation bit5", rd_data, 32'h20);
        write_word(32'hFFFF_FFFF);
        chk("R5 commutation kept by write one", rd_data, 32'h20);
        evt_commut = 1'b1;
        wr_en = 1'b1; wr_data = 32'h0;
        @(negedge clk);
        evt_commut = 1'b0; wr_en = 1'b0;
        chk("R3 commutation set beats clear", rd_data, 32'h20);
        clear_all();
    endtask

    task automatic trig_step(input logic lvl, input logic exp_set, input string req);
        trig_in = lvl;
        wait_cyc(2);
        chk({req, " not yet after two edges"}, rd_data, 32'h0);
        @(negedge clk);
        chk(req, rd_data, exp_set ? 32'h40 : 32'h0);
        wait_cyc(1);
        clear_all();
    endtask

    task automatic t_trig_normal();
        pause_mode = 1'b0;
        trig_pol = 1'b0;
        trig_step(1'b1, 1'b1, "R6 rising edge, rise polarity");
        trig_step(1'b0, 1'b0, "R6 falling edge ignored, rise polarity");
        trig_pol = 1'b1;
        trig_step(1'b1, 1'b0, "R6 rising edge ignored, fall polarity");
        trig_step(1'b0, 1'b1, "R6 falling edge, fall polarity");
    endtask

    task automatic t_trig_pause();
        pause_mode = 1'b1;
        trig_pol = 1'b0;
        trig_step(1'b1, 1'b1, "R7 pause rising edge");
        trig_step(1'b0, 1'b1, "R7 pause falling edge");
        trig_pol = 1'b1;
        trig_step(1'b1, 1'b1, "R7 pause rising edge, fall polarity");
        trig_step(1'b0, 1'b1, "R7 pause falling edge, fall polarity");
        pause_mode = 1'b0;
        trig_pol = 1'b0;
    endtask

    task automatic t_break();
        brk_active = 1'b1;
        @(negedge clk);
        chk("R8 break bit7 set", rd_data, 32'h80);
        write_word(32'h0);
        chk("R8 break clear blocked while active", rd_data, 32'h80);
        brk_active = 1'b0;
        @(negedge clk);
        write_word(32'h0);
        chk("R8 break cleared once inactive", rd_data, 32'h0);
    endtask

    task automatic t_reserved();
        write_word(32'hFFFF_FFFF);
        chk("R9 reserved read zero after write ones", rd_data, 32'h0);
        evt_update = 1'b1; evt_commut = 1'b1; evt_ch = 4'hF; brk_active = 1'b1;
        @(negedge clk);
        evt_update = 1'b0; evt_commut = 1'b0; evt_ch = 4'h0; brk_active = 1'b0;
        chk("R9 bits 8 and 31..13 zero, all set", rd_data & 32'hFFFF_E100, 32'h0);
        @(negedge clk);
        clear_all();
    endtask

    task automatic t_irq();
        evt_update = 1'b1;
        @(negedge clk);
        evt_update = 1'b0;
        irq_en = 32'hFFFF_FFFE;
        #1;
        chk("R10 irq low, flag not enabled", {31'b0, irq}, 32'h0);
        irq_en = 32'h0000_0001;
        #1;
        chk("R10 irq high, flag enabled", {31'b0, irq}, 32'h1);
        clear_all();
        chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
        irq_en = 32'h0;
    endtask

    initial begin
        t_reset();
        t_update_channels();
        t_write_clear();
        t_set_wins();
        t_overcapture();
        t_commut();
        t_trig_normal();
        t_trig_pause();
        t_break();
        t_reserved();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule